// File: doc/BRIEF.md
# Windowed Command and Status Port

This block is the control front end that a host sees on a network adapter. A single 16-bit location takes command words on a write and returns a status word on a read. A second location returns the number of the register window that is currently selected. Each command word carries a 5-bit opcode in its upper bits and an 11-bit argument below it. The commands select the window, enable or reset the transmit and receive engines, and load the interrupt mask, the receive address filter and three threshold values.

The transmit and receive engines report events through a vector of one-cycle pulses. The block latches each event into a status bit, which stays set until the host acknowledges it with a bit mask. The interrupt output is raised while any latched event is also enabled in the mask. The engine controls are plain level and pulse pins. No data stream passes through the block, so it has no valid/ready handshake. A write is accepted in the cycle in which it is presented, and a read returns the value of the selected location in the same cycle.

Top module: `cmdport_top`

## Requirements
- R1: A write is taken as a command only when `wr_en` is high and `wr_addr` is 0xE. Writes to any other offset change no state.
- R2: Opcode 0x01 loads argument bits 2:0 as the window number. The window appears in status bits 15:13 and in bits 2:0 of a read at offset 0xF, whose other bits are 0.
- R3: A pulse on `evt_in` bit 1, 2, 3, 4, 5 or 7 sets the status bit at the same position on the next clock edge. The bit stays set until it is acknowledged or cleared by a reset. `evt_in` bits 0 and 6 are ignored.
- R4: Opcode 0x0D clears each status bit in 7:1 whose argument bit at the same position is 1. If an event arrives in the same cycle as its acknowledge, the event wins and the bit stays set.
- R5: Opcode 0x0E loads argument bits 7:0 as the interrupt mask. `irq` is the OR over bits 7:1 of (latched events AND mask). Status bit 0 always equals `irq`.
- R6: Opcode 0x0C sets status bit 6 (interrupt requested).
- R7: Opcodes 0x04 and 0x03 set and clear `rx_en`. Opcodes 0x09 and 0x0A set and clear `tx_en`. Both are 0 after any reset.
- R8: Opcode 0x05 gives a one-cycle pulse on `rx_rst`, and opcode 0x0B gives one on `tx_rst`, in the cycle after the write.
- R9: Opcode 0x10 loads argument bits 3:0 into `rx_filter`. Bit 0 accepts the own address, bit 1 multicast, bit 2 broadcast and bit 3 all frames.
- R10: Opcodes 0x11, 0x12 and 0x13 load the full 11-bit argument into the RX early, TX available and TX start thresholds. While the RX early threshold is 2047, `evt_in` bit 5 is not latched. While the TX available threshold is 2047, `evt_in` bit 3 is not latched.
- R11: Status bit 12 (busy) is 1 for exactly 4 cycles after opcodes 0x00, 0x05 and 0x0B, and for 1 cycle after any other command. A new command restarts the count.
- R12: Opcode 0x00 and `rst_n` low clear the window, all latched events, the mask, the filter, the thresholds and both enables. They also ignore events in that cycle. Opcode 0x00 also pulses both `rx_rst` and `tx_rst`.
- R13: Opcodes not listed here only start the 1-cycle busy. Status bits 11:8 read 0, and reads at offsets other than 0xE and 0xF return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write offset |
| wr_data | input | 16 | Command word: opcode 15:11, argument 10:0 |
| rd_addr | input | 4 | Host read offset |
| rd_data | output | 16 | Read value of `rd_addr` |
| evt_in | input | 8 | Event pulses from the engines, one per status position |
| irq | output | 1 | Interrupt request |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| rx_rst | output | 1 | Receiver reset pulse |
| tx_rst | output | 1 | Transmitter reset pulse |
| rx_filter | output | 4 | Receive address filter |
| rx_early_thr | output | 11 | RX early threshold |
| tx_avail_thr | output | 11 | TX available threshold |
| tx_start_thr | output | 11 | TX start threshold |

## Verification
Directed sequences come first. One sets an acknowledge and an event on the same bit, which shows whether the set or the clear takes priority. Another parks a threshold at 2047 and then pulses its event, which shows whether the event is blocked or latched. A global reset is issued with every event input high, which tells a long busy window from a short one and shows whether reset clears events that arrive in the same cycle. A write to another offset and an unknown opcode follow; they tell a real decode from a partial one.

A seeded random stream then mixes every opcode with random arguments, sparse event pulses, stray offsets and occasional 2047 thresholds. A reference model in the bench checks every output pin and the status fields in every cycle. This separates wrong bit positions and lost events from errors in mask combining.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_GLOBAL_RST = 5'h00,
    OP_WIN_SEL    = 5'h01,
    OP_RX_OFF     = 5'h03,
    OP_RX_ON      = 5'h04,
    OP_RX_RST     = 5'h05,
    OP_TX_ON      = 5'h09,
    OP_TX_OFF     = 5'h0a,
    OP_TX_RST     = 5'h0b,
    OP_REQ_IRQ    = 5'h0c,
    OP_ACK        = 5'h0d,
    OP_SET_MASK   = 5'h0e,
    OP_SET_FILT   = 5'h10,
    OP_THR_RXE    = 5'h11,
    OP_THR_TXA    = 5'h12,
    OP_THR_TXS    = 5'h13
  } opcode_e;

  typedef struct packed {
    logic glob_rst;
    logic win_sel;
    logic rx_off;
    logic rx_on;
    logic rx_rst;
    logic tx_on;
    logic tx_off;
    logic tx_rst;
    logic req_irq;
    logic ack;
    logic set_mask;
    logic set_filt;
    logic thr_rxe;
    logic thr_txa;
    logic thr_txs;
  } cmd_dec_t;

  // event positions shared by status word, ack mask and interrupt mask
  localparam int EV_FAIL   = 1;
  localparam int EV_TXDONE = 2;
  localparam int EV_TXAV   = 3;
  localparam int EV_RXDONE = 4;
  localparam int EV_RXE    = 5;
  localparam int EV_REQ    = 6;
  localparam int EV_STATS  = 7;

endpackage

// File: rtl/cmdport_decode.sv
module cmdport_decode
  import cmdport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CMD_W    = 16,
  parameter int CMD_OFFS = 14
) (
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CMD_W-1:0]        wr_data,
  output logic                    fire,
  output logic                    long_cmd,
  output cmd_dec_t                dec,
  output logic [CMD_W-OP_W-1:0]   arg
);
  localparam int ARG_W = CMD_W - OP_W;

  logic [OP_W-1:0] op;

  assign op   = wr_data[CMD_W-1 -: OP_W];
  assign arg  = wr_data[ARG_W-1:0];
  assign fire = wr_en && (wr_addr == ADDR_W'(CMD_OFFS));

  always_comb begin
    dec = '0;
    if (fire) begin
      case (op)
        OP_GLOBAL_RST: dec.glob_rst = 1'b1;
        OP_WIN_SEL:    dec.win_sel  = 1'b1;
        OP_RX_OFF:     dec.rx_off   = 1'b1;
        OP_RX_ON:      dec.rx_on    = 1'b1;
        OP_RX_RST:     dec.rx_rst   = 1'b1;
        OP_TX_ON:      dec.tx_on    = 1'b1;
        OP_TX_OFF:     dec.tx_off   = 1'b1;
        OP_TX_RST:     dec.tx_rst   = 1'b1;
        OP_REQ_IRQ:    dec.req_irq  = 1'b1;
        OP_ACK:        dec.ack      = 1'b1;
        OP_SET_MASK:   dec.set_mask = 1'b1;
        OP_SET_FILT:   dec.set_filt = 1'b1;
        OP_THR_RXE:    dec.thr_rxe  = 1'b1;
        OP_THR_TXA:    dec.thr_txa  = 1'b1;
        OP_THR_TXS:    dec.thr_txs  = 1'b1;
        default:       dec = '0;
      endcase
    end
  end

  assign long_cmd = dec.glob_rst | dec.rx_rst | dec.tx_rst;

  // R1: at most one command strobe per write, and only on the command offset
  always_comb begin
    a_r1_one_hot_decode: assert ($onehot0(dec));
    if (!fire) a_r1_offset_gate: assert (dec == '0);
  end

endmodule

// File: rtl/cmdport_busy.sv
module cmdport_busy #(
  parameter int LONG_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic long_cmd,
  output logic busy
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (fire)       cnt_q <= long_cmd ? CNT_W'(LONG_CYC) : CNT_W'(1);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  a_r11_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy);
  a_r11_short_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !long_cmd) ##1 !fire |=> !busy);
  a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fire) |=> !busy);

endmodule

// File: rtl/cmdport_cfg.sv
module cmdport_cfg
  import cmdport_pkg::*;
#(
  parameter int ARG_W  = 11,
  parameter int WIN_W  = 3,
  parameter int EVT_W  = 8,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_dec_t          dec,
  input  logic [ARG_W-1:0]  arg,
  output logic [WIN_W-1:0]  win,
  output logic [EVT_W-1:0]  mask,
  output logic [FILT_W-1:0] filt,
  output logic [ARG_W-1:0]  thr_rxe,
  output logic [ARG_W-1:0]  thr_txa,
  output logic [ARG_W-1:0]  thr_txs,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rx_rst,
  output logic              tx_rst
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win     <= '0;
      mask    <= '0;
      filt    <= '0;
      thr_rxe <= '0;
      thr_txa <= '0;
      thr_txs <= '0;
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      rx_rst  <= 1'b0;
      tx_rst  <= 1'b0;
    end else begin
      rx_rst <= dec.rx_rst | dec.glob_rst;
      tx_rst <= dec.tx_rst | dec.glob_rst;
      if (dec.glob_rst) begin
        win     <= '0;
        mask    <= '0;
        filt    <= '0;
        thr_rxe <= '0;
        thr_txa <= '0;
        thr_txs <= '0;
        rx_en   <= 1'b0;
        tx_en   <= 1'b0;
      end else begin
        if (dec.win_sel)  win     <= arg[WIN_W-1:0];
        if (dec.set_mask) mask    <= arg[EVT_W-1:0];
        if (dec.set_filt) filt    <= arg[FILT_W-1:0];
        if (dec.thr_rxe)  thr_rxe <= arg;
        if (dec.thr_txa)  thr_txa <= arg;
        if (dec.thr_txs)  thr_txs <= arg;
        if (dec.rx_on)       rx_en <= 1'b1;
        else if (dec.rx_off) rx_en <= 1'b0;
        if (dec.tx_on)       tx_en <= 1'b1;
        else if (dec.tx_off) tx_en <= 1'b0;
      end
    end
  end

  a_r12_global_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dec.glob_rst |=> (win == '0 && mask == '0 && filt == '0 && !rx_en && !tx_en
                      && thr_rxe == '0 && thr_txa == '0 && thr_txs == '0));
  a_r7_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
    dec.rx_on |=> rx_en);
  a_r7_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    dec.tx_off |=> !tx_en);
  a_r8_rx_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |-> $past(dec.rx_rst || dec.glob_rst));
  a_r8_tx_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |-> $past(dec.tx_rst || dec.glob_rst));
  a_r2_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec.win_sel && !dec.glob_rst) |=> $stable(win));

endmodule

// File: rtl/cmdport_events.sv
module cmdport_events
  import cmdport_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_in,
  input  logic             req_irq,
  input  logic             ack,
  input  logic [EVT_W-1:0] ack_bits,
  input  logic             clr,
  input  logic             rxe_off,
  input  logic             txa_off,
  output logic [EVT_W-1:0] lat
);
  // positions that engines may set; bit 0 is the summary and bit 6 is host-only
  localparam logic [EVT_W-1:0] SRC_MASK =
    EVT_W'((1 << EV_FAIL) | (1 << EV_TXDONE) | (1 << EV_TXAV) |
           (1 << EV_RXDONE) | (1 << EV_RXE) | (1 << EV_STATS));
  localparam logic [EVT_W-1:0] LAT_MASK = ~EVT_W'(1);

  logic [EVT_W-1:0] set_v, clr_v;

  always_comb begin
    set_v = evt_in & SRC_MASK;
    if (rxe_off) set_v[EV_RXE]  = 1'b0;
    if (txa_off) set_v[EV_TXAV] = 1'b0;
    if (req_irq) set_v[EV_REQ]  = 1'b1;
    clr_v = ack ? ack_bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lat <= '0;
    else if (clr) lat <= '0;
    else          lat <= ((lat & ~clr_v) | set_v) & LAT_MASK;
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ack && !req_irq && (evt_in & SRC_MASK) == '0) |=> $stable(lat));
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !clr) |=> ((lat & $past(ack_bits & ~set_v) & LAT_MASK) == '0));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (set_v & LAT_MASK) != '0) |=> ((lat & $past(set_v & LAT_MASK)) == $past(set_v & LAT_MASK)));
  a_r10_rxe_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rxe_off && !lat[EV_RXE]) |=> !lat[EV_RXE]);
  a_r6_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && !clr) |=> lat[EV_REQ]);
  a_r12_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lat == '0));

endmodule

// File: rtl/cmdport_top.sv
module cmdport_top
  import cmdport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CMD_W    = 16,
  parameter int WIN_W    = 3,
  parameter int EVT_W    = 8,
  parameter int FILT_W   = 4,
  parameter int CMD_OFFS = 14,
  parameter int WIN_OFFS = 15,
  parameter int LONG_CYC = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [CMD_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [CMD_W-1:0]           rd_data,
  input  logic [EVT_W-1:0]           evt_in,
  output logic                       irq,
  output logic                       rx_en,
  output logic                       tx_en,
  output logic                       rx_rst,
  output logic                       tx_rst,
  output logic [FILT_W-1:0]          rx_filter,
  output logic [CMD_W-OP_W-1:0]      rx_early_thr,
  output logic [CMD_W-OP_W-1:0]      tx_avail_thr,
  output logic [CMD_W-OP_W-1:0]      tx_start_thr
);
  localparam int ARG_W   = CMD_W - OP_W;
  localparam int BUSY_B  = CMD_W - WIN_W - 1;
  localparam int GAP_W   = BUSY_B - EVT_W;
  localparam logic [ARG_W-1:0] THR_OFF = '1;

  logic              fire, long_cmd, busy;
  cmd_dec_t          dec;
  logic [ARG_W-1:0]  arg;
  logic [WIN_W-1:0]  win;
  logic [EVT_W-1:0]  mask, lat;
  logic [CMD_W-1:0]  status;

  cmdport_decode #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .CMD_OFFS(CMD_OFFS)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fire(fire), .long_cmd(long_cmd), .dec(dec), .arg(arg)
  );

  cmdport_busy #(.LONG_CYC(LONG_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .fire(fire), .long_cmd(long_cmd), .busy(busy)
  );

  cmdport_cfg #(
    .ARG_W(ARG_W), .WIN_W(WIN_W), .EVT_W(EVT_W), .FILT_W(FILT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .dec(dec), .arg(arg),
    .win(win), .mask(mask), .filt(rx_filter),
    .thr_rxe(rx_early_thr), .thr_txa(tx_avail_thr), .thr_txs(tx_start_thr),
    .rx_en(rx_en), .tx_en(tx_en), .rx_rst(rx_rst), .tx_rst(tx_rst)
  );

  cmdport_events #(.EVT_W(EVT_W)) u_events (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .req_irq(dec.req_irq), .ack(dec.ack), .ack_bits(arg[EVT_W-1:0]),
    .clr(dec.glob_rst),
    .rxe_off(rx_early_thr == THR_OFF), .txa_off(tx_avail_thr == THR_OFF),
    .lat(lat)
  );

  // lat[0] is held at 0 by the latch stage, so it never contributes
  assign irq = |(lat & mask);

  always_comb begin
    status = '0;
    status[CMD_W-1 -: WIN_W] = win;
    status[BUSY_B]           = busy;
    status[EVT_W-1:1]        = lat[EVT_W-1:1];
    status[0]                = irq;
  end

  always_comb begin
    if (rd_addr == ADDR_W'(CMD_OFFS))      rd_data = status;
    else if (rd_addr == ADDR_W'(WIN_OFFS)) rd_data = CMD_W'(win);
    else                                   rd_data = '0;
  end

  a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0 && lat != '0));
  a_r13_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[BUSY_B-1 -: GAP_W] == '0);
  a_r10_txa_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_avail_thr == THR_OFF && !lat[EV_TXAV]) |=> !lat[EV_TXAV]);

endmodule

// File: tb/cmdport_top_tb.sv
`timescale 1ns/1ps
module cmdport_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [7:0]  evt_in;
  logic        irq, rx_en, tx_en, rx_rst, tx_rst;
  logic [3:0]  rx_filter;
  logic [10:0] rx_early_thr, tx_avail_thr, tx_start_thr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic [2:0]  m_win;
  logic [7:0]  m_lat, m_mask;
  logic [3:0]  m_filt;
  logic [10:0] m_rxe, m_txa, m_txs;
  logic        m_rxen, m_txen, m_rxrst, m_txrst;
  int          m_busy;

  always #10 clk = ~clk;

  cmdport_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_in(evt_in), .irq(irq), .rx_en(rx_en), .tx_en(tx_en),
    .rx_rst(rx_rst), .tx_rst(tx_rst), .rx_filter(rx_filter),
    .rx_early_thr(rx_early_thr), .tx_avail_thr(tx_avail_thr),
    .tx_start_thr(tx_start_thr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |(m_lat[7:1] & m_mask[7:1]);
  endfunction

  task automatic model_clear();
    m_win = '0; m_lat = '0; m_mask = '0; m_filt = '0;
    m_rxe = '0; m_txa = '0; m_txs = '0; m_rxen = 0; m_txen = 0;
  endtask

  task automatic model_step(input logic w, input logic [3:0] a,
                            input logic [15:0] d, input logic [7:0] e);
    logic [7:0]  evs;
    logic [4:0]  op;
    logic [10:0] arg;
    m_rxrst = 0; m_txrst = 0;
    if (m_busy > 0) m_busy--;
    evs = e & 8'hBE;
    if (m_rxe == 11'h7FF) evs[5] = 0;
    if (m_txa == 11'h7FF) evs[3] = 0;
    if (w && a == 4'hE) begin
      op  = d[15:11];
      arg = d[10:0];
      m_busy = (op == 5'h00 || op == 5'h05 || op == 5'h0b) ? 4 : 1;
      case (op)
        5'h00: begin model_clear(); m_rxrst = 1; m_txrst = 1; return; end
        5'h01: m_win = arg[2:0];
        5'h03: m_rxen = 0;
        5'h04: m_rxen = 1;
        5'h05: m_rxrst = 1;
        5'h09: m_txen = 1;
        5'h0a: m_txen = 0;
        5'h0b: m_txrst = 1;
        5'h0c: evs[6] = 1;
        5'h0d: m_lat = m_lat & ~arg[7:0];
        5'h0e: m_mask = arg[7:0];
        5'h10: m_filt = arg[3:0];
        5'h11: m_rxe = arg;
        5'h12: m_txa = arg;
        5'h13: m_txs = arg;
        default: ;
      endcase
    end
    m_lat = (m_lat | evs) & 8'hFE;
  endtask

  task automatic compare_all();
    if (rd_addr == 4'hE) begin
      chk("R2 status window", rd_data[15:13], m_win);
      chk("R11 status busy", rd_data[12], m_busy != 0);
      chk("R13 status gap", rd_data[11:8], 0);
      chk("R3 R4 status events", rd_data[7:1], m_lat[7:1]);
      chk("R5 status latch", rd_data[0], exp_irq());
    end else if (rd_addr == 4'hF) begin
      chk("R2 window read", rd_data, {13'b0, m_win});
    end else begin
      chk("R13 unmapped read", rd_data, 0);
    end
    chk("R5 irq", irq, exp_irq());
    chk("R7 rx_en", rx_en, m_rxen);
    chk("R7 tx_en", tx_en, m_txen);
    chk("R8 rx_rst", rx_rst, m_rxrst);
    chk("R8 tx_rst", tx_rst, m_txrst);
    chk("R9 filter", rx_filter, m_filt);
    chk("R10 rx early thr", rx_early_thr, m_rxe);
    chk("R10 tx avail thr", tx_avail_thr, m_txa);
    chk("R10 tx start thr", tx_start_thr, m_txs);
  endtask

  task automatic cyc(input logic w, input logic [3:0] a, input logic [15:0] d,
                     input logic [7:0] e, input logic [3:0] ra);
    wr_en = w; wr_addr = a; wr_data = d; evt_in = e; rd_addr = ra;
    model_step(w, a, d, e);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [15:0] cmd(input logic [4:0] op, input logic [10:0] arg);
    return {op, arg};
  endfunction

  initial begin
    logic [4:0] ops [16] = '{5'h00, 5'h01, 5'h03, 5'h04, 5'h05, 5'h09, 5'h0a, 5'h0b,
                             5'h0c, 5'h0d, 5'h0e, 5'h10, 5'h11, 5'h12, 5'h13, 5'h1f};
    void'($urandom(32'd2718));
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; evt_in = 0; rd_addr = 4'hE;
    model_clear(); m_busy = 0; m_rxrst = 0; m_txrst = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset status", rd_data, 0);
    chk("R7 reset enables", {rx_en, tx_en}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: window select, read at 0xF
    cyc(1, 4'hE, cmd(5'h01, 11'd7), 0, 4'hF);
    chk("R2 window is 7", rd_data, 16'd7);
    // R1: same command at another offset is ignored
    cyc(1, 4'h6, cmd(5'h01, 11'd2), 0, 4'hF);
    chk("R1 off-offset write ignored", rd_data, 16'd7);
    // R6: request interrupt
    cyc(1, 4'hE, cmd(5'h0c, 11'd0), 0, 4'hE);
    chk("R6 requested bit", rd_data[6], 1);
    // R5: unmask bit 6
    cyc(1, 4'hE, cmd(5'h0e, 11'h040), 0, 4'hE);
    chk("R5 irq after mask", irq, 1);
    // R4: ack all while RX complete arrives: event wins
    cyc(1, 4'hE, cmd(5'h0d, 11'h0FF), 8'h10, 4'hE);
    chk("R4 ack with event", rd_data[7:0], 8'h10);
    chk("R4 irq dropped", irq, 0);
    // R10: RX early threshold at 2047 blocks bit 5
    cyc(1, 4'hE, cmd(5'h11, 11'h7FF), 0, 4'hE);
    cyc(0, 4'hE, 0, 8'h20, 4'hE);
    chk("R10 blocked rx early", rd_data[5], 0);
    // R13: unknown opcode
    cyc(1, 4'hE, cmd(5'h1f, 11'h7FF), 8'h00, 4'hF);
    chk("R13 unknown opcode", rd_data, 16'd7);
    // R12, R11: global reset with all events high
    cyc(1, 4'hE, cmd(5'h00, 11'h000), 8'hFF, 4'hE);
    chk("R12 cleared status", {rd_data[15:13], rd_data[7:0]}, 0);
    chk("R12 reset pulses", {rx_rst, tx_rst}, 2'b11);
    chk("R11 long busy 1", rd_data[12], 1);
    for (int i = 2; i <= 4; i++) begin
      cyc(0, 4'hE, 0, 0, 4'hE);
      chk("R11 long busy", rd_data[12], 1);
    end
    cyc(0, 4'hE, 0, 0, 4'hE);
    chk("R11 long busy ends", rd_data[12], 0);
    // R11: short busy
    cyc(1, 4'hE, cmd(5'h04, 11'h0), 0, 4'hE);
    chk("R11 short busy", rd_data[12], 1);
    cyc(0, 4'hE, 0, 0, 4'hE);
    chk("R11 short busy ends", rd_data[12], 0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic        w;
      logic [3:0]  a, ra;
      logic [4:0]  op;
      logic [10:0] arg;
      logic [7:0]  e;
      w  = ($urandom % 2) == 0;
      a  = (($urandom % 8) == 0) ? 4'($urandom) : 4'hE;
      op = ops[$urandom % 16];
      if (op == 5'h00 && ($urandom % 6) != 0) op = 5'h0d;
      arg = 11'($urandom);
      if ((op == 5'h11 || op == 5'h12 || op == 5'h13) && ($urandom % 4) == 0) arg = 11'h7FF;
      e  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      case ($urandom % 4)
        0: ra = 4'hF;
        1: ra = 4'($urandom);
        default: ra = 4'hE;
      endcase
      cyc(w, a, cmd(op, arg), e, ra);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule